// File: doc/BRIEF.md
# Extended immediate-mode ALU

This block is the immediate-operand execution slice of an 8-bit accumulator CPU. It runs the combined AND-then-shift, AND-then-carry and AND-then-subtract operations that take a single immediate byte. It also runs the ordinary subtract-with-carry path, which two opcodes share. Each operation takes the opcode byte, the immediate byte, the current accumulator, the X register and the four arithmetic flags. It produces the next values of those registers and a write strobe for each register it changes.

The sequencer raises `valid_i` for one cycle per instruction, and results are captured on that edge. In the following cycle `done_o` is high, and the outputs and strobes hold the result of that instruction. Arithmetic is always binary, so there is no decimal-mode input. Any opcode outside the supported set raises `unsup_o` and passes the current register and flag values through without asserting any strobe.

The flag vector is ordered {N, V, Z, C}: bit 3 is N, bit 2 is V, bit 1 is Z and bit 0 is C.

Top module: `imm_alu`

## Requirements
- R1: Opcode 0x4B ANDs A with the immediate and shifts the result right by one, with a zero entering bit 7. C takes the bit shifted out, N and Z follow the new A, and V is kept. With immediate 0xFE the resulting C is 0.
- R2: Opcodes 0x0B and 0x2B write A = A AND immediate. N and Z follow the result, C equals result bit 7, and V is kept. With immediate 0x00 the result is A = 0, Z = 1 and C = 0.
- R3: Opcode 0x6B ANDs A with the immediate, then rotates the result right with the incoming C entering bit 7. N and Z follow the result, C is result bit 6, and V is result bit 6 XOR result bit 5.
- R4: Opcode 0xCB writes X = (A AND X) minus the immediate, modulo 256, and ignores the incoming C. C is 1 exactly when (A AND X) >= immediate. N and Z follow the new X, V is kept, and A is not written (the A strobe stays low).
- R5: Opcodes 0xE9 and 0xEB both write A = A + (255 - immediate) + C in binary. C is the carry out of bit 7, V is the signed overflow, and N and Z follow A. The two opcodes give identical results.
- R6: Any other opcode sets `unsup_o`, asserts no write strobe, and returns A, X and the flags unchanged on the outputs.
- R7: Results and strobes appear in the cycle after `valid_i`, with `done_o` high for exactly that cycle. Without `valid_i` all strobes and `done_o` are low.
- R8: While reset is asserted, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Execute the presented instruction |
| opcode_i | input | 8 | Opcode byte |
| imm_i | input | 8 | Immediate operand |
| acc_i | input | 8 | Current accumulator |
| xr_i | input | 8 | Current X register |
| flags_i | input | 4 | Current flags {N,V,Z,C} |
| acc_o | output | 8 | Next accumulator |
| xr_o | output | 8 | Next X register |
| flags_o | output | 4 | Next flags {N,V,Z,C} |
| acc_we_o | output | 1 | Accumulator write strobe |
| xr_we_o | output | 1 | X write strobe |
| flg_we_o | output | 1 | Flag write strobe |
| unsup_o | output | 1 | Opcode not supported |
| done_o | output | 1 | Result valid this cycle |

## Verification
Several properties are checked on every cycle:
- Strobes and the unsupported flag never appear without a preceding valid pulse.
- An unsupported result never carries a strobe.
- The shift opcode always clears N and result bit 7.
- The AND-carry opcode always makes C equal to N.
- The rotate opcode always makes V equal to C XOR result bit 5.
- The subtract-into-X opcode never writes A.

Other behaviour can only be shown by the bench's scenarios, which compare every result against an independent model:
- the exact arithmetic values;
- the carry of the X subtraction at the equal, less-than and greater-than points;
- the named immediate corner cases;
- the identity of the two subtract opcodes;
- pass-through on unsupported opcodes.

// File: rtl/imm_alu.sv
module imm_alu #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid_i,
  input  logic [7:0]   opcode_i,
  input  logic [W-1:0] imm_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] xr_i,
  input  logic [3:0]   flags_i,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] xr_o,
  output logic [3:0]   flags_o,
  output logic         acc_we_o,
  output logic         xr_we_o,
  output logic         flg_we_o,
  output logic         unsup_o,
  output logic         done_o
);
  localparam int FC = 0, FZ = 1, FV = 2, FN = 3;

  logic [W-1:0] anded, a_nx, x_nx;
  logic [3:0]   f_nx;
  logic         wa, wx, wf, bad;
  logic [W:0]   sbc_sum, axs_diff;

  assign anded    = acc_i & imm_i;
  assign sbc_sum  = {1'b0, acc_i} + {1'b0, ~imm_i} + {{W{1'b0}}, flags_i[FC]};
  assign axs_diff = {1'b0, acc_i & xr_i} - {1'b0, imm_i};

  always_comb begin
    a_nx = acc_i;
    x_nx = xr_i;
    f_nx = flags_i;
    wa = 1'b0;
    wx = 1'b0;
    wf = 1'b0;
    bad = 1'b0;
    case (opcode_i)
      8'h4B: begin
        a_nx = {1'b0, anded[W-1:1]};
        f_nx[FC] = anded[0];
        wa = 1'b1;
        wf = 1'b1;
      end
      8'h0B, 8'h2B: begin
        a_nx = anded;
        f_nx[FC] = anded[W-1];
        wa = 1'b1;
        wf = 1'b1;
      end
      8'h6B: begin
        a_nx = {flags_i[FC], anded[W-1:1]};
        f_nx[FC] = anded[W-1];
        f_nx[FV] = anded[W-1] ^ anded[W-2];
        wa = 1'b1;
        wf = 1'b1;
      end
      8'hCB: begin
        x_nx = axs_diff[W-1:0];
        f_nx[FC] = ~axs_diff[W];
        wx = 1'b1;
        wf = 1'b1;
      end
      8'hE9, 8'hEB: begin
        a_nx = sbc_sum[W-1:0];
        f_nx[FC] = sbc_sum[W];
        f_nx[FV] = (acc_i[W-1] ^ sbc_sum[W-1]) & (~imm_i[W-1] ^ sbc_sum[W-1]);
        wa = 1'b1;
        wf = 1'b1;
      end
      default: bad = 1'b1;
    endcase
    if (wa) begin
      f_nx[FN] = a_nx[W-1];
      f_nx[FZ] = (a_nx == '0);
    end
    if (wx) begin
      f_nx[FN] = x_nx[W-1];
      f_nx[FZ] = (x_nx == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_o    <= '0;
      xr_o     <= '0;
      flags_o  <= '0;
      acc_we_o <= 1'b0;
      xr_we_o  <= 1'b0;
      flg_we_o <= 1'b0;
      unsup_o  <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o   <= valid_i;
      acc_we_o <= valid_i & wa;
      xr_we_o  <= valid_i & wx;
      flg_we_o <= valid_i & wf;
      unsup_o  <= valid_i & bad;
      if (valid_i) begin
        acc_o   <= a_nx;
        xr_o    <= x_nx;
        flags_o <= f_nx;
      end
    end
  end
endmodule

module imm_alu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         valid_i,
  input logic [7:0]   opcode_i,
  input logic [W-1:0] acc_o,
  input logic [3:0]   flags_o,
  input logic         acc_we_o,
  input logic         xr_we_o,
  input logic         flg_we_o,
  input logic         unsup_o,
  input logic         done_o
);
  assert_strobe_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_we_o | xr_we_o | flg_we_o | unsup_o | done_o) |-> $past(valid_i));

  assert_unsup_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    unsup_o |-> !(acc_we_o | xr_we_o | flg_we_o));

  assert_shift_clears_top_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(valid_i && opcode_i == 8'h4B) |-> (!acc_o[W-1] && !flags_o[3] && acc_we_o));

  assert_carry_equals_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(valid_i && (opcode_i == 8'h0B || opcode_i == 8'h2B)) |-> (flags_o[0] == flags_o[3]));

  assert_rotate_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(valid_i && opcode_i == 8'h6B) |-> (flags_o[2] == (flags_o[0] ^ acc_o[W-3])));

  assert_axs_keeps_acc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(valid_i && opcode_i == 8'hCB) |-> (!acc_we_o && xr_we_o && flg_we_o));
endmodule

bind imm_alu imm_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .opcode_i(opcode_i),
  .acc_o(acc_o), .flags_o(flags_o), .acc_we_o(acc_we_o), .xr_we_o(xr_we_o),
  .flg_we_o(flg_we_o), .unsup_o(unsup_o), .done_o(done_o)
);

// File: tb/imm_alu_test.sv
module imm_alu_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0;
  logic [7:0] opcode_i = '0, imm_i = '0, acc_i = '0, xr_i = '0;
  logic [3:0] flags_i = '0;
  logic [7:0] acc_o, xr_o;
  logic [3:0] flags_o;
  logic acc_we_o, xr_we_o, flg_we_o, unsup_o, done_o;

  typedef struct {
    logic [7:0] a;
    logic [7:0] x;
    logic [3:0] f;
    logic [3:0] we;
    string      tag;
  } exp_t;

  exp_t sb[$];
  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  imm_alu uut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .opcode_i(opcode_i), .imm_i(imm_i),
    .acc_i(acc_i), .xr_i(xr_i), .flags_i(flags_i), .acc_o(acc_o), .xr_o(xr_o),
    .flags_o(flags_o), .acc_we_o(acc_we_o), .xr_we_o(xr_we_o), .flg_we_o(flg_we_o),
    .unsup_o(unsup_o), .done_o(done_o)
  );

  task automatic check(input string tag, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [7:0] op, input logic [7:0] im,
                                 input logic [7:0] a, input logic [7:0] x, input logic [3:0] f);
    exp_t e;
    logic n, v, z, c;
    logic [7:0] t;
    int s;
    {n, v, z, c} = f;
    e.a = a;
    e.x = x;
    e.we = 4'b0000;
    t = a & im;
    case (op)
      8'h4B: begin e.a = t / 2; c = t[0]; e.we = 4'b1010; e.tag = "R1"; end
      8'h0B, 8'h2B: begin e.a = t; c = t[7]; e.we = 4'b1010; e.tag = "R2"; end
      8'h6B: begin
        e.a = (t / 2) + (c ? 8'h80 : 8'h00);
        c = e.a[6];
        v = e.a[6] != e.a[5];
        e.we = 4'b1010;
        e.tag = "R3";
      end
      8'hCB: begin
        s = int'(a & x) - int'(im);
        c = s >= 0;
        e.x = 8'(s + 256);
        e.we = 4'b0110;
        e.tag = "R4";
      end
      8'hE9, 8'hEB: begin
        s = int'(a) + 255 - int'(im) + int'(c);
        e.a = 8'(s);
        c = s > 255;
        v = (int'($signed(a)) - int'($signed(im)) - 1 + int'(f[0])) > 127 ||
            (int'($signed(a)) - int'($signed(im)) - 1 + int'(f[0])) < -128;
        e.we = 4'b1010;
        e.tag = "R5";
      end
      default: begin e.we = 4'b0001; e.tag = "R6"; end
    endcase
    if (e.we[3]) begin n = e.a[7]; z = e.a == 0; end
    if (e.we[2]) begin n = e.x[7]; z = e.x == 0; end
    e.f = {n, v, z, c};
    return e;
  endfunction

  task automatic drive(input logic [7:0] op, input logic [7:0] im,
                       input logic [7:0] a, input logic [7:0] x, input logic [3:0] f);
    opcode_i = op; imm_i = im; acc_i = a; xr_i = x; flags_i = f;
    valid_i = 1'b1;
    sb.push_back(model(op, im, a, x, f));
    @(negedge clk);
  endtask

  task automatic idle();
    valid_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && done_o) begin
        if (sb.size() == 0) begin
          check("R7", 1, 0, "unexpected done");
        end else begin
          e = sb.pop_front();
          check(e.tag, acc_o, e.a, "acc");
          check(e.tag, xr_o, e.x, "x");
          check(e.tag, flags_o, e.f, "flags");
          check(e.tag, {acc_we_o, xr_we_o, flg_we_o, unsup_o}, e.we, "strobes");
        end
      end else if (rst_n) begin
        check("R7", {acc_we_o, xr_we_o, flg_we_o, unsup_o}, 0, "idle strobes");
      end
    end
  end

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        bad++;
        total++;
        $display("FAIL watchdog R7 actual=%0d expected=%0d", cyc, 20000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin : stim
    logic [7:0] lf;
    repeat (3) @(negedge clk);
    check("R8", {acc_o, xr_o, flags_o}, 0, "reset data");
    check("R8", {acc_we_o, xr_we_o, flg_we_o, unsup_o, done_o}, 0, "reset strobes");
    rst_n = 1'b1;
    idle();
    drive(8'h4B, 8'hFE, 8'hFF, 8'h00, 4'b0101);
    drive(8'h4B, 8'h0F, 8'h03, 8'h00, 4'b0100);
    drive(8'h4B, 8'h01, 8'h01, 8'h00, 4'b0000);
    drive(8'h0B, 8'h00, 8'hFF, 8'h00, 4'b1101);
    drive(8'h2B, 8'h80, 8'hFF, 8'h00, 4'b0000);
    drive(8'h0B, 8'h7F, 8'h3C, 8'h00, 4'b0101);
    drive(8'h6B, 8'hFF, 8'hFF, 8'h00, 4'b0001);
    drive(8'h6B, 8'h60, 8'hFF, 8'h00, 4'b0000);
    drive(8'h6B, 8'h40, 8'hC0, 8'h00, 4'b0000);
    drive(8'h6B, 8'h01, 8'h01, 8'h00, 4'b0000);
    idle();
    drive(8'hCB, 8'h10, 8'hF0, 8'h3C, 4'b0100);
    drive(8'hCB, 8'h40, 8'hF0, 8'h3C, 4'b0101);
    drive(8'hCB, 8'h30, 8'hF0, 8'h3C, 4'b0000);
    drive(8'hCB, 8'h31, 8'hF0, 8'h3C, 4'b0001);
    drive(8'hE9, 8'hB0, 8'h50, 8'h00, 4'b0001);
    drive(8'hEB, 8'hB0, 8'h50, 8'h00, 4'b0001);
    drive(8'hE9, 8'h01, 8'h00, 8'h00, 4'b0000);
    drive(8'hEB, 8'h01, 8'h00, 8'h00, 4'b0000);
    drive(8'hEB, 8'h50, 8'h50, 8'h00, 4'b0001);
    drive(8'hA9, 8'h12, 8'h34, 8'h56, 4'b1011);
    drive(8'h8B, 8'hFF, 8'hAA, 8'h55, 4'b0110);
    idle();
    idle();
    lf = 8'h5D;
    for (int i = 0; i < 300; i++) begin
      logic [7:0] op;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      case (i % 7)
        0: op = 8'h4B;
        1: op = 8'h0B;
        2: op = 8'h6B;
        3: op = 8'hCB;
        4: op = 8'hE9;
        5: op = 8'hEB;
        default: op = lf;
      endcase
      drive(op, lf ^ 8'hA5, {lf[3:0], lf[7:4]}, lf + 8'd17, lf[3:0]);
      if (i % 5 == 0) idle();
    end
    idle();
    idle();
    check("R7", sb.size(), 0, "scoreboard drained");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule